// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This block programs a contiguous range of bytes into an ultraviolet-erasable or one-time-programmable EPROM with a pulse-and-verify loop. It fetches each target byte from a request interface: it presents a source address, and the surrounding logic returns the byte on `src_data`. It then drives the device's address, data, chip-select, read-strobe and program-strobe lines. Supply levels are requested from external voltage control through digital select flags. The sequencer waits for a ready acknowledge before it touches the device.

For every byte it first reads the current contents. A byte that already matches is skipped. A byte that would need a 0 turned back into a 1 stops the run with a pre-check error. Otherwise it applies program pulses of fixed width, each followed at once by a verify read, until the byte matches or the retry limit is reached. No extra pulse follows a good verify. After the last address, the whole range is read back twice: once at the raised check supply and once at the lowered check supply. All strobe timings are derived from one clock-frequency parameter through a single timer.

Top module: `eprom_prog_seq`

## Requirements
- R1: Each program pulse holds `ep_pgm_n` low for exactly PULSE_US × CLK_MHZ clock cycles (100 µs by default).
- R2: `ep_doe`, `ep_addr` and `ep_dout` are driven and stable for at least 2 µs before `ep_pgm_n` falls. They stay stable while it is low, and the data stays driven at least 2 µs after it rises.
- R3: Reads pull `ep_oe_n` low only with `ep_pgm_n` high and `ep_doe` low, and at least 2 µs after the data drive was released. `ep_addr` does not change while `ep_oe_n` is low.
- R4: After each pulse the byte is verified. On a match, one `pc_valid` strobe reports the address and the number of pulses used, and the device then holds the target byte.
- R5: When the 25th pulse (MAX_PULSES) still fails verify, the run stops with `fail_phase` = 2 and `fail_addr` set to that address. No further pulse is issued and no later address is touched.
- R6: No pulse follows a passing verify. A byte whose pre-read already equals the target gets zero pulses and reports a count of 0.
- R7: Before pulsing a byte, if the target has a 1 where the pre-read holds a 0, the run stops with `fail_phase` = 1 at that address and no pulse is applied to it.
- R8: After the last address, every byte is read with `vpp_req` = 0, first with `vcc_sel` = 2 (raised check level) and then with `vcc_sel` = 3 (lowered check level). Any mismatch stops the run with `fail_phase` = 3 at that address.
- R9: Reset and idle state: `ep_ce_n`, `ep_oe_n`, `ep_pgm_n` high, `ep_doe`, `vpp_req`, `vcc_sel` and `done` zero. At the end, `done` = 1 and stays set until the next `start`. `pass` = 1 only with `fail_phase` = 0, and `max_pulses` holds the largest pulse count applied to any byte, including a failing one.
- R10: Programming runs with `vpp_req` = 1 and `vcc_sel` = 1. After every supply change, `ep_ce_n` stays high until `sup_rdy` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted when idle or done) |
| start_addr | input | ADDR_W | First address of the range |
| end_addr | input | ADDR_W | Last address of the range |
| src_addr | output | ADDR_W | Address of the requested target byte |
| src_data | input | DATA_W | Target byte for `src_addr` |
| ep_addr | output | ADDR_W | Device address |
| ep_dout | output | DATA_W | Data driven to the device |
| ep_doe | output | 1 | Data drive enable |
| ep_din | input | DATA_W | Data read from the device |
| ep_ce_n | output | 1 | Chip select, active low |
| ep_oe_n | output | 1 | Read strobe, active low |
| ep_pgm_n | output | 1 | Program strobe, active low |
| vpp_req | output | 1 | Request programming voltage |
| vcc_sel | output | 2 | Supply select: 0 nominal, 1 program, 2 high check, 3 low check |
| sup_rdy | input | 1 | Supply settled acknowledge |
| pc_valid | output | 1 | Per-byte pulse report strobe |
| pc_addr | output | ADDR_W | Address of the reported byte |
| pc_count | output | PC_W | Pulses used for the reported byte |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished without error |
| fail_phase | output | 2 | 0 none, 1 pre-check, 2 retry limit, 3 readback |
| fail_addr | output | ADDR_W | Address of the failure |
| max_pulses | output | PC_W | Largest pulse count applied to one byte |

## Verification
The device model lets each byte need its own number of pulses before it takes the data. A mixed range with counts of 1, 3, 0 and 2 separates the retry loop from the skip path and from any overprogramming. A byte needing exactly 25 pulses, set against one needing 26, pins down the limit to the cycle. A byte that already holds a 0 where its target has a 1 separates the pre-check from the retry failure. A cell that reads correctly only at the raised check level shows that both readback passes run, in the right order.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SUP_SET,
    S_SUP_WAIT,
    S_RD_GAP,
    S_RD_OE,
    S_RD_END,
    S_SETUP,
    S_PULSE,
    S_HOLD,
    S_ADV,
    S_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_PROG   = 2'd0,
    PH_CHK_HI = 2'd1,
    PH_CHK_LO = 2'd2
  } seq_phase_e;

  localparam logic [1:0] VSEL_NOM    = 2'd0;
  localparam logic [1:0] VSEL_PRG    = 2'd1;
  localparam logic [1:0] VSEL_CHK_HI = 2'd2;
  localparam logic [1:0] VSEL_CHK_LO = 2'd3;

  localparam logic [1:0] FAIL_NONE = 2'd0;
  localparam logic [1:0] FAIL_PRE  = 2'd1;
  localparam logic [1:0] FAIL_PRG  = 2'd2;
  localparam logic [1:0] FAIL_CHK  = 2'd3;

endpackage

// File: rtl/eprom_us_timer.sv
// Converts a wait in microseconds into clock cycles and counts it down.
module eprom_us_timer #(
  parameter int CLK_MHZ = 200,
  parameter int MAX_US  = 100,
  parameter int US_W    = $clog2(MAX_US + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [US_W-1:0] load_us,
  output logic            expired
);
  localparam int CNT_W = $clog2(MAX_US * CLK_MHZ + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CNT_W'(32'(load_us) * CLK_MHZ - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/eprom_seq_fsm.sv
module eprom_seq_fsm
  import eprom_seq_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int PULSE_US   = 100,
  parameter int GAP_US     = 2,
  parameter int READ_US    = 1,
  parameter int MAX_PULSES = 25,
  parameter int US_W       = $clog2(PULSE_US + 1),
  parameter int PC_W       = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic [DATA_W-1:0] src_data,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              sup_rdy,
  input  logic              tmr_exp,
  output seq_state_e        state,
  output seq_phase_e        phase,
  output logic [ADDR_W-1:0] addr,
  output logic              tmr_ld,
  output logic [US_W-1:0]   tmr_us,
  output logic              pc_valid,
  output logic [ADDR_W-1:0] pc_addr,
  output logic [PC_W-1:0]   pc_count,
  output logic              done,
  output logic              pass,
  output logic [1:0]        fail_phase,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [PC_W-1:0]   max_pulses
);
  seq_state_e        nxt;
  logic [ADDR_W-1:0] first_q, last_q;
  logic [DATA_W-1:0] rd_q;
  logic [PC_W-1:0]   pcnt_q;
  logic              ver_q;

  logic              match, blocked, at_lim, at_last, accept;
  logic              byte_ok, go_setup, go_adv;
  logic [1:0]        fail_code;
  logic [PC_W-1:0]   pcnt_inc;

  assign match    = (rd_q == src_data);
  assign blocked  = |(src_data & ~rd_q);
  assign at_lim   = (pcnt_q == PC_W'(MAX_PULSES));
  assign at_last  = (addr == last_q);
  assign accept   = start && (state == S_IDLE || state == S_DONE);
  assign pcnt_inc = pcnt_q + 1'b1;

  // verdict of the read that just completed
  always_comb begin
    byte_ok   = 1'b0;
    go_setup  = 1'b0;
    fail_code = FAIL_NONE;
    if (phase == PH_PROG) begin
      if (!ver_q) begin
        if (blocked)    fail_code = FAIL_PRE;
        else if (match) byte_ok   = 1'b1;
        else            go_setup  = 1'b1;
      end else begin
        if (match)       byte_ok   = 1'b1;
        else if (at_lim) fail_code = FAIL_PRG;
        else             go_setup  = 1'b1;
      end
    end else if (!match) begin
      fail_code = FAIL_CHK;
    end
    go_adv = !go_setup && (fail_code == FAIL_NONE);
  end

  always_comb begin
    nxt    = state;
    tmr_ld = 1'b0;
    tmr_us = US_W'(GAP_US);
    unique case (state)
      S_IDLE, S_DONE: if (start) begin nxt = S_SUP_SET; tmr_ld = 1'b1; end
      S_SUP_SET:  if (tmr_exp) nxt = S_SUP_WAIT;
      S_SUP_WAIT: if (sup_rdy) begin nxt = S_RD_GAP; tmr_ld = 1'b1; end
      S_RD_GAP:   if (tmr_exp) begin nxt = S_RD_OE; tmr_ld = 1'b1; tmr_us = US_W'(READ_US); end
      S_RD_OE:    if (tmr_exp) nxt = S_RD_END;
      S_RD_END: begin
        if (go_setup)    begin nxt = S_SETUP; tmr_ld = 1'b1; end
        else if (go_adv) nxt = S_ADV;
        else             nxt = S_DONE;
      end
      S_SETUP: if (tmr_exp) begin nxt = S_PULSE; tmr_ld = 1'b1; tmr_us = US_W'(PULSE_US); end
      S_PULSE: if (tmr_exp) begin nxt = S_HOLD; tmr_ld = 1'b1; end
      S_HOLD:  if (tmr_exp) begin nxt = S_RD_GAP; tmr_ld = 1'b1; end
      S_ADV: begin
        if (at_last && phase == PH_CHK_LO) nxt = S_DONE;
        else begin
          nxt    = at_last ? S_SUP_SET : S_RD_GAP;
          tmr_ld = 1'b1;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      phase      <= PH_PROG;
      addr       <= '0;
      first_q    <= '0;
      last_q     <= '0;
      rd_q       <= '0;
      pcnt_q     <= '0;
      ver_q      <= 1'b0;
      pc_valid   <= 1'b0;
      pc_addr    <= '0;
      pc_count   <= '0;
      done       <= 1'b0;
      pass       <= 1'b0;
      fail_phase <= FAIL_NONE;
      fail_addr  <= '0;
      max_pulses <= '0;
    end else begin
      state    <= nxt;
      pc_valid <= 1'b0;
      if (accept) begin
        addr       <= start_addr;
        first_q    <= start_addr;
        last_q     <= end_addr;
        phase      <= PH_PROG;
        pcnt_q     <= '0;
        ver_q      <= 1'b0;
        done       <= 1'b0;
        pass       <= 1'b0;
        fail_phase <= FAIL_NONE;
        fail_addr  <= '0;
        max_pulses <= '0;
      end
      if (state == S_RD_OE && tmr_exp) rd_q <= rd_data;
      if (state == S_SETUP && tmr_exp) begin
        pcnt_q <= pcnt_inc;
        if (pcnt_inc > max_pulses) max_pulses <= pcnt_inc;
      end
      if (state == S_HOLD && tmr_exp) ver_q <= 1'b1;
      if (state == S_RD_END) begin
        if (byte_ok) begin
          pc_valid <= 1'b1;
          pc_addr  <= addr;
          pc_count <= pcnt_q;
        end
        if (fail_code != FAIL_NONE) begin
          done       <= 1'b1;
          fail_phase <= fail_code;
          fail_addr  <= addr;
        end
      end
      if (state == S_ADV) begin
        pcnt_q <= '0;
        ver_q  <= 1'b0;
        if (!at_last) begin
          addr <= addr + 1'b1;
        end else begin
          addr <= first_q;
          unique case (phase)
            PH_PROG:   phase <= PH_CHK_HI;
            PH_CHK_HI: phase <= PH_CHK_LO;
            default: begin done <= 1'b1; pass <= 1'b1; end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/eprom_pin_drv.sv
// Registered decode of the sequencer state onto the device and supply lines.
module eprom_pin_drv
  import eprom_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_e        state,
  input  seq_phase_e        phase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] ep_addr,
  output logic [DATA_W-1:0] ep_dout,
  output logic              ep_doe,
  output logic              ep_ce_n,
  output logic              ep_oe_n,
  output logic              ep_pgm_n,
  output logic              vpp_req,
  output logic [1:0]        vcc_sel
);
  logic active, selected, driving;

  assign active   = !(state inside {S_IDLE, S_DONE});
  assign selected = state inside {S_RD_GAP, S_RD_OE, S_RD_END, S_SETUP, S_PULSE, S_HOLD, S_ADV};
  assign driving  = state inside {S_SETUP, S_PULSE, S_HOLD};

  always_ff @(posedge clk) begin
    if (rst) begin
      ep_addr  <= '0;
      ep_dout  <= '0;
      ep_doe   <= 1'b0;
      ep_ce_n  <= 1'b1;
      ep_oe_n  <= 1'b1;
      ep_pgm_n <= 1'b1;
      vpp_req  <= 1'b0;
      vcc_sel  <= VSEL_NOM;
    end else begin
      ep_addr  <= addr;
      if (state == S_SETUP) ep_dout <= src_data;
      ep_doe   <= driving;
      ep_ce_n  <= !selected;
      ep_oe_n  <= (state != S_RD_OE);
      ep_pgm_n <= (state != S_PULSE);
      vpp_req  <= active && (phase == PH_PROG);
      if (!active)                vcc_sel <= VSEL_NOM;
      else if (phase == PH_PROG)  vcc_sel <= VSEL_PRG;
      else if (phase == PH_CHK_HI) vcc_sel <= VSEL_CHK_HI;
      else                        vcc_sel <= VSEL_CHK_LO;
    end
  end
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprom_seq_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int CLK_MHZ    = 200,
  parameter int PULSE_US   = 100,
  parameter int GAP_US     = 2,
  parameter int READ_US    = 1,
  parameter int MAX_PULSES = 25,
  parameter int PC_W       = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] ep_addr,
  output logic [DATA_W-1:0] ep_dout,
  output logic              ep_doe,
  input  logic [DATA_W-1:0] ep_din,
  output logic              ep_ce_n,
  output logic              ep_oe_n,
  output logic              ep_pgm_n,
  output logic              vpp_req,
  output logic [1:0]        vcc_sel,
  input  logic              sup_rdy,
  output logic              pc_valid,
  output logic [ADDR_W-1:0] pc_addr,
  output logic [PC_W-1:0]   pc_count,
  output logic              done,
  output logic              pass,
  output logic [1:0]        fail_phase,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [PC_W-1:0]   max_pulses
);
  localparam int US_W = $clog2(PULSE_US + 1);

  seq_state_e        state;
  seq_phase_e        phase;
  logic [ADDR_W-1:0] addr;
  logic              tmr_ld, tmr_exp;
  logic [US_W-1:0]   tmr_us;

  assign src_addr = addr;

  eprom_us_timer #(.CLK_MHZ(CLK_MHZ), .MAX_US(PULSE_US), .US_W(US_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_ld), .load_us(tmr_us), .expired(tmr_exp)
  );

  eprom_seq_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_US(PULSE_US), .GAP_US(GAP_US),
    .READ_US(READ_US), .MAX_PULSES(MAX_PULSES), .US_W(US_W), .PC_W(PC_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .end_addr(end_addr),
    .src_data(src_data), .rd_data(ep_din), .sup_rdy(sup_rdy), .tmr_exp(tmr_exp),
    .state(state), .phase(phase), .addr(addr), .tmr_ld(tmr_ld), .tmr_us(tmr_us),
    .pc_valid(pc_valid), .pc_addr(pc_addr), .pc_count(pc_count), .done(done),
    .pass(pass), .fail_phase(fail_phase), .fail_addr(fail_addr), .max_pulses(max_pulses)
  );

  eprom_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst(rst), .state(state), .phase(phase), .addr(addr), .src_data(src_data),
    .ep_addr(ep_addr), .ep_dout(ep_dout), .ep_doe(ep_doe), .ep_ce_n(ep_ce_n),
    .ep_oe_n(ep_oe_n), .ep_pgm_n(ep_pgm_n), .vpp_req(vpp_req), .vcc_sel(vcc_sel)
  );
endmodule

// File: rtl/eprom_prog_seq_chk.sv
module eprom_prog_seq_chk #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int MAX_PULSES = 25,
  parameter int PC_W       = $clog2(MAX_PULSES + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [ADDR_W-1:0] ep_addr,
  input logic [DATA_W-1:0] ep_dout,
  input logic              ep_doe,
  input logic              ep_oe_n,
  input logic              ep_pgm_n,
  input logic              vpp_req,
  input logic [1:0]        vcc_sel,
  input logic              pc_valid,
  input logic [PC_W-1:0]   pc_count,
  input logic              done,
  input logic              pass,
  input logic [1:0]        fail_phase
);
  // R2
  pgm_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ep_pgm_n) |-> $past(ep_doe) && ep_doe);
  // R2
  pgm_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!ep_pgm_n && $past(!ep_pgm_n)) |-> $stable(ep_addr) && $stable(ep_dout));
  // R2
  pgm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ep_pgm_n) |-> ep_doe);
  // R3
  read_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ep_oe_n) |-> !ep_doe && !$past(ep_doe) && ep_pgm_n);
  // R3
  read_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (!ep_oe_n && $past(!ep_oe_n)) |-> $stable(ep_addr));
  // R5
  pulse_limit_chk: assert property (@(posedge clk) disable iff (rst)
    pc_valid |-> pc_count <= PC_W'(MAX_PULSES));
  // R8
  check_supply_chk: assert property (@(posedge clk) disable iff (rst)
    (!ep_oe_n && vcc_sel[1]) |-> !vpp_req);
  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done && $stable(fail_phase));
  // R9
  pass_clean_chk: assert property (@(posedge clk) disable iff (rst)
    pass |-> done && fail_phase == 2'd0);
endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_PULSES(MAX_PULSES), .PC_W(PC_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .ep_addr(ep_addr), .ep_dout(ep_dout),
  .ep_doe(ep_doe), .ep_oe_n(ep_oe_n), .ep_pgm_n(ep_pgm_n), .vpp_req(vpp_req),
  .vcc_sel(vcc_sel), .pc_valid(pc_valid), .pc_count(pc_count), .done(done),
  .pass(pass), .fail_phase(fail_phase)
);

// File: tb/tb_eprom_prog_seq.sv
module tb_eprom_prog_seq;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int MHZ = 2;        // timing ratio shortened for run length
  localparam int PUS = 100;
  localparam int MAXP = 25;
  localparam int PCW = $clog2(MAXP + 1);
  localparam int GAPC = 2 * MHZ;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;        // 200 MHz

  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0, end_addr = '0, src_addr, ep_addr, pc_addr, fail_addr;
  logic [DW-1:0] src_data, ep_dout, ep_din;
  logic ep_doe, ep_ce_n, ep_oe_n, ep_pgm_n, vpp_req, sup_rdy, pc_valid, done, pass;
  logic [1:0] vcc_sel, fail_phase;
  logic [PCW-1:0] pc_count, max_pulses;

  eprom_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_MHZ(MHZ), .PULSE_US(PUS), .MAX_PULSES(MAXP)) dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .end_addr(end_addr),
    .src_addr(src_addr), .src_data(src_data), .ep_addr(ep_addr), .ep_dout(ep_dout),
    .ep_doe(ep_doe), .ep_din(ep_din), .ep_ce_n(ep_ce_n), .ep_oe_n(ep_oe_n),
    .ep_pgm_n(ep_pgm_n), .vpp_req(vpp_req), .vcc_sel(vcc_sel), .sup_rdy(sup_rdy),
    .pc_valid(pc_valid), .pc_addr(pc_addr), .pc_count(pc_count), .done(done), .pass(pass),
    .fail_phase(fail_phase), .fail_addr(fail_addr), .max_pulses(max_pulses)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] tgt [256];
  int need [256];
  int got  [256];
  logic weak_en = 1'b0;
  logic [AW-1:0] weak_addr = '0;
  logic [15:0] exp_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // device and source models
  assign src_data = tgt[src_addr];
  assign ep_din = (!ep_ce_n && !ep_oe_n)
                ? (mem[ep_addr] ^ ((weak_en && ep_addr == weak_addr && vcc_sel == 2'b11) ? 8'h01 : 8'h00))
                : 8'hFF;

  int rcnt = 0;
  logic [2:0] sup_prev = '0;
  always @(negedge clk) begin
    if (rst || {vpp_req, vcc_sel} != sup_prev) rcnt = 0;
    else if (rcnt < 10) rcnt++;
    sup_prev = {vpp_req, vcc_sel};
  end
  assign sup_rdy = (rcnt >= 10);

  // protocol monitor and cell model
  logic p_pgm = 1'b1, p_oe = 1'b1, p_doe = 1'b0;
  int lo_cnt = 0, su_cnt = 0, ho_cnt = 0, gp_cnt = 0, ce_viol = 0, rd_hi = 0, rd_lo = 0;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (p_pgm && !ep_pgm_n) begin
        got[ep_addr]++;
        if (got[ep_addr] >= need[ep_addr]) mem[ep_addr] = mem[ep_addr] & ep_dout;
        chk(su_cnt >= GAPC, "R2 setup before pulse", su_cnt, GAPC);
        chk(vpp_req && vcc_sel == 2'b01, "R10 program supply at pulse", int'(vcc_sel), 1);
      end
      if (!p_pgm && ep_pgm_n) chk(lo_cnt == PUS * MHZ, "R1 pulse width", lo_cnt, PUS * MHZ);
      if (p_doe && !ep_doe) chk(ho_cnt >= GAPC, "R2 data hold", ho_cnt, GAPC);
      if (p_oe && !ep_oe_n) begin
        chk(gp_cnt >= GAPC && ep_pgm_n, "R3 release to read gap", gp_cnt, GAPC);
        if (vcc_sel == 2'b10) rd_hi++;
        if (vcc_sel == 2'b11) rd_lo++;
      end
      if (!ep_ce_n && !sup_rdy) ce_viol++;
      lo_cnt = !ep_pgm_n ? lo_cnt + 1 : 0;
      su_cnt = (ep_doe && ep_pgm_n) ? su_cnt + 1 : 0;
      if (!ep_pgm_n) ho_cnt = 0; else if (ep_doe) ho_cnt++;
      if (ep_doe) gp_cnt = 0; else if (ep_oe_n) gp_cnt++;
    end
    p_pgm = ep_pgm_n; p_oe = ep_oe_n; p_doe = ep_doe;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && pc_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected pulse report", int'(pc_addr), -1);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(pc_addr == e[15:8] && 8'(pc_count) == e[7:0], "R4 per-byte pulse count",
            int'({pc_addr, 8'(pc_count)}), int'(e));
      end
    end
  end

  // watchdog
  always @(negedge clk) begin
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic clear_dev();
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'hFF; tgt[i] = 8'hFF; need[i] = 1; got[i] = 0;
    end
    weak_en = 1'b0; ce_viol = 0; rd_hi = 0; rd_lo = 0;
    exp_q.delete();
  endtask

  task automatic expect_byte(input int a, input int n);
    exp_q.push_back({8'(a), 8'(n)});
  endtask

  task automatic run(input int sa, input int ea, input bit e_pass, input int e_ph,
                     input int e_fa, input int e_max, input string tag);
    @(negedge clk);
    start_addr = AW'(sa); end_addr = AW'(ea); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(pass == e_pass, {tag, " R9 pass"}, int'(pass), int'(e_pass));
    chk(int'(fail_phase) == e_ph, {tag, " fail phase"}, int'(fail_phase), e_ph);
    if (!e_pass) chk(int'(fail_addr) == e_fa, {tag, " fail address"}, int'(fail_addr), e_fa);
    chk(int'(max_pulses) == e_max, {tag, " R9 max pulses"}, int'(max_pulses), e_max);
    chk(exp_q.size() == 0, {tag, " R4 all reports seen"}, exp_q.size(), 0);
    chk(ce_viol == 0, {tag, " R10 select before ready"}, ce_viol, 0);
    chk(ep_ce_n && ep_pgm_n && !vpp_req && vcc_sel == 2'b00, {tag, " R9 idle lines"},
        int'({ep_ce_n, ep_pgm_n, vpp_req, vcc_sel}), 5'b11000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(ep_ce_n && ep_oe_n && ep_pgm_n && !ep_doe && !vpp_req && vcc_sel == 2'b00 && !done,
        "R9 reset state", int'({ep_ce_n, ep_oe_n, ep_pgm_n, ep_doe, vpp_req, done}), 6'b111000);
    rst = 1'b0;
    repeat (20) @(negedge clk);

    // mixed pulse needs, one byte already programmed
    clear_dev();
    tgt[8'h10] = 8'hA5; need[8'h10] = 1;
    tgt[8'h11] = 8'h3C; need[8'h11] = 3;
    tgt[8'h13] = 8'h00; need[8'h13] = 2;
    expect_byte(8'h10, 1); expect_byte(8'h11, 3); expect_byte(8'h12, 0); expect_byte(8'h13, 2);
    run(8'h10, 8'h13, 1'b1, 0, 0, 3, "mixed");
    chk(got[8'h10] == 1 && got[8'h11] == 3 && got[8'h13] == 2, "R6 no extra pulse",
        got[8'h11], 3);
    chk(got[8'h12] == 0, "R6 matching byte untouched", got[8'h12], 0);
    chk(mem[8'h11] == 8'h3C && mem[8'h13] == 8'h00, "R4 device holds target",
        int'(mem[8'h11]), 8'h3C);
    chk(rd_hi == 4 && rd_lo == 4, "R8 two readback passes", rd_hi * 10 + rd_lo, 44);

    // exactly at the limit
    clear_dev();
    tgt[8'h20] = 8'h7E; need[8'h20] = MAXP;
    expect_byte(8'h20, MAXP);
    run(8'h20, 8'h20, 1'b1, 0, 0, MAXP, "limit");

    // one beyond the limit
    clear_dev();
    tgt[8'h30] = 8'h0F; need[8'h30] = MAXP + 1;
    tgt[8'h31] = 8'h00;
    run(8'h30, 8'h31, 1'b0, 2, 8'h30, MAXP, "R5 over");
    chk(got[8'h30] == MAXP, "R5 pulses stop at limit", got[8'h30], MAXP);
    chk(got[8'h31] == 0, "R5 later byte untouched", got[8'h31], 0);

    // zero-to-one request
    clear_dev();
    tgt[8'h40] = 8'h55;
    mem[8'h41] = 8'h0F; tgt[8'h41] = 8'h1F;
    expect_byte(8'h40, 1);
    run(8'h40, 8'h42, 1'b0, 1, 8'h41, 1, "R7 precheck");
    chk(got[8'h41] == 0, "R7 no pulse on blocked byte", got[8'h41], 0);

    // readback fails only at the low check level
    clear_dev();
    tgt[8'h50] = 8'h12; tgt[8'h51] = 8'h34;
    weak_en = 1'b1; weak_addr = 8'h51;
    expect_byte(8'h50, 1); expect_byte(8'h51, 1);
    run(8'h50, 8'h51, 1'b0, 3, 8'h51, 1, "R8 low level");
    chk(rd_hi == 2 && rd_lo == 2, "R8 high pass then low pass", rd_hi * 10 + rd_lo, 22);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule